// File: doc/BRIEF.md
# Segment-mapped DRAM address multiplexer

This block sits between a 16-bit processor bus, a video fetch engine and a 256 kB dynamic RAM array organised as sixteen 16 kB blocks. The processor space is cut into four 16 kB windows, picked by the top two address bits. Each window is steered to any of the sixteen blocks by a 4-bit selector nibble. The 18-bit physical address is then split over a 9-bit multiplexed DRAM address bus: one half goes out in the row phase and the other half in the column phase.

The selector nibbles come from two 8-bit mapping ports. Each port line is either driven by a software-written value or left floating. A floating line reads high, except that a power-up hold pulls four chosen lines low, so that the machine starts with the top four blocks in ascending order.

When the video engine owns the bus, the block uses the window-3 selector for the top two physical bits. It takes the middle two bits from the inverted video bank pins and the low fourteen bits from the video address. The processor address plays no part in a video fetch.

Top module: `dram_segmux`

## Requirements
- R1: With `vid_own`=0, `cpu_addr[15:14]` selects the window, and `phys_addr` equals {selected 4-bit block, `cpu_addr[13:0]`}.
- R2: Window 0 uses port A pins 3:0, window 1 uses port A pins 7:4, window 2 uses port B pins 3:0 and window 3 uses port B pins 7:4, with the higher pin as the block MSB.
- R3: With `row_phase`=1, `ma[7:0]` equals `phys_addr[7:0]` and `ma[8]` equals `phys_addr[16]`.
- R4: With `row_phase`=0, `ma[7:0]` equals `phys_addr[15:8]` and `ma[8]` equals `phys_addr[17]`.
- R5: `ma` follows `row_phase` combinationally, with no clock involved.
- R6: With `vid_own`=1, the window-3 selector is used whatever `cpu_addr` holds, and `cpu_addr` has no effect on `phys_addr`.
- R7: With `vid_own`=1, `phys_addr[13:0]` equals `vid_addr`, `phys_addr[15:14]` equals the inverse of `vid_bank_n`, and `phys_addr[17:16]` equals port B pins 7:6.
- R8: A port line whose direction bit is 1 reads its value bit. A line whose direction bit is 0 reads 1, unless `boot_hold`=1 and the line is port A bit 0, 1 or 5, or port B bit 0, in which case it reads 0.
- R9: With both direction bytes 0 and `boot_hold`=1, windows 0, 1, 2 and 3 map to blocks 0xC, 0xD, 0xE and 0xF.
- R10: `boot_hold` has no effect on lines whose direction bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | Processor address |
| vid_own | input | 1 | 1 when the video engine owns the bus |
| vid_addr | input | 14 | Video fetch address within 16 kB |
| vid_bank_n | input | 2 | Video bank bits, active-low |
| pa_val | input | 8 | Mapping port A written value |
| pa_dir | input | 8 | Mapping port A direction (1 = driven) |
| pb_val | input | 8 | Mapping port B written value |
| pb_dir | input | 8 | Mapping port B direction (1 = driven) |
| boot_hold | input | 1 | Power-up pull-down of the four start-up lines |
| row_phase | input | 1 | 1 = row phase, 0 = column phase |
| ma | output | 9 | Multiplexed DRAM address |
| phys_addr | output | 18 | Full physical address, for test |

## Verification
A video fetch and a change to the window-3 selector can happen in the same cycle. Port B pins 7:6 act both as the top of the window-3 block and as the top of the video physical address. The bench provokes this by rewriting `pb_val` while `vid_own` is held high. It then checks `phys_addr[17:16]` and the ninth `ma` line in both phases against the new pin values, and checks that the bank-derived bits 15:14 stay where they were. A second overlap is the boot pull-down acting on a port that is only partly driven; the bench judges this per window nibble.

// File: rtl/dram_segmux_pkg.sv
package dram_segmux_pkg;
  localparam int CPU_AW  = 16;
  localparam int OFS_W   = 14;
  localparam int BLK_W   = 4;
  localparam int SEG_N   = 4;
  localparam int SEG_W   = $clog2(SEG_N);
  localparam int PORT_W  = 8;
  localparam int PHYS_W  = BLK_W + OFS_W;
  localparam int MUX_W   = 9;
  localparam int HALF_W  = MUX_W - 1;
  localparam int VBANK_W = CPU_AW - OFS_W;

  // lines pulled low by the power-up hold
  localparam logic [PORT_W-1:0] HOLD_MASK_A = 8'b0010_0011;
  localparam logic [PORT_W-1:0] HOLD_MASK_B = 8'b0000_0001;

  typedef logic [PHYS_W-1:0] phys_t;
  typedef logic [MUX_W-1:0]  mux_t;
  typedef logic [BLK_W-1:0]  blk_t;

  function automatic logic pin_level(input logic val, input logic drv,
                                     input logic hold, input logic held_line);
    if (drv) return val;
    return !(hold && held_line);
  endfunction

  function automatic mux_t row_word(input phys_t p);
    return {p[PHYS_W-2], p[HALF_W-1:0]};
  endfunction

  function automatic mux_t col_word(input phys_t p);
    return {p[PHYS_W-1], p[2*HALF_W-1:HALF_W]};
  endfunction
endpackage

// File: rtl/dsm_port_pins.sv
module dsm_port_pins
  import dram_segmux_pkg::*;
#(
  parameter int              W         = PORT_W,
  parameter logic [W-1:0]    HELD_MASK = '0
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] drv,
  input  logic         hold,
  output logic [W-1:0] pins
);
  for (genvar i = 0; i < W; i++) begin : g_line
    assign pins[i] = pin_level(val[i], drv[i], hold, HELD_MASK[i]);
  end
endmodule

// File: rtl/dsm_seg_map.sv
module dsm_seg_map
  import dram_segmux_pkg::*;
(
  input  logic [PORT_W-1:0] pins_a,
  input  logic [PORT_W-1:0] pins_b,
  input  logic [SEG_W-1:0]  seg_idx,
  output logic [BLK_W-1:0]  blk
);
  localparam int ALL_W = 2 * PORT_W;
  logic [ALL_W-1:0] all_pins;
  logic [BLK_W-1:0] nib [SEG_N];

  assign all_pins = {pins_b, pins_a};

  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    assign nib[s] = all_pins[s*BLK_W +: BLK_W];
  end

  assign blk = nib[seg_idx];
endmodule

// File: rtl/dsm_phys_form.sv
module dsm_phys_form
  import dram_segmux_pkg::*;
(
  input  logic               vid_own,
  input  logic [OFS_W-1:0]   cpu_ofs,
  input  logic [OFS_W-1:0]   vid_addr,
  input  logic [VBANK_W-1:0] vid_bank_n,
  input  logic [BLK_W-1:0]   blk,
  output logic [PHYS_W-1:0]  phys
);
  localparam int HI_W = BLK_W - VBANK_W;
  always_comb begin
    if (vid_own)
      phys = {blk[BLK_W-1 -: HI_W], ~vid_bank_n, vid_addr};
    else
      phys = {blk, cpu_ofs};
  end
endmodule

// File: rtl/dsm_dram_mux.sv
module dsm_dram_mux
  import dram_segmux_pkg::*;
(
  input  logic [PHYS_W-1:0] phys,
  input  logic              row_phase,
  output logic [MUX_W-1:0]  ma
);
  assign ma = row_phase ? row_word(phys) : col_word(phys);
endmodule

// File: rtl/dram_segmux.sv
module dram_segmux
  import dram_segmux_pkg::*;
(
  input  logic [15:0] cpu_addr,
  input  logic        vid_own,
  input  logic [13:0] vid_addr,
  input  logic [1:0]  vid_bank_n,
  input  logic [7:0]  pa_val,
  input  logic [7:0]  pa_dir,
  input  logic [7:0]  pb_val,
  input  logic [7:0]  pb_dir,
  input  logic        boot_hold,
  input  logic        row_phase,
  output logic [8:0]  ma,
  output logic [17:0] phys_addr
);
  logic [PORT_W-1:0] pins_a;
  logic [PORT_W-1:0] pins_b;
  logic [SEG_W-1:0]  seg_idx;
  logic [BLK_W-1:0]  blk_sel;

  // a video fetch leaves the top processor lines floating high
  assign seg_idx = vid_own ? {SEG_W{1'b1}} : cpu_addr[CPU_AW-1 -: SEG_W];

  dsm_port_pins #(.W(PORT_W), .HELD_MASK(HOLD_MASK_A)) u_pa (
    .val(pa_val), .drv(pa_dir), .hold(boot_hold), .pins(pins_a)
  );
  dsm_port_pins #(.W(PORT_W), .HELD_MASK(HOLD_MASK_B)) u_pb (
    .val(pb_val), .drv(pb_dir), .hold(boot_hold), .pins(pins_b)
  );
  dsm_seg_map u_map (
    .pins_a(pins_a), .pins_b(pins_b), .seg_idx(seg_idx), .blk(blk_sel)
  );
  dsm_phys_form u_phys (
    .vid_own(vid_own), .cpu_ofs(cpu_addr[OFS_W-1:0]), .vid_addr(vid_addr),
    .vid_bank_n(vid_bank_n), .blk(blk_sel), .phys(phys_addr)
  );
  dsm_dram_mux u_mux (
    .phys(phys_addr), .row_phase(row_phase), .ma(ma)
  );
endmodule

// File: rtl/dram_segmux_chk.sv
module dram_segmux_chk (
  input logic [15:0] cpu_addr,
  input logic        vid_own,
  input logic [13:0] vid_addr,
  input logic [1:0]  vid_bank_n,
  input logic [7:0]  pa_val,
  input logic [7:0]  pa_dir,
  input logic [7:0]  pb_val,
  input logic [7:0]  pb_dir,
  input logic        boot_hold,
  input logic        row_phase,
  input logic [8:0]  ma,
  input logic [17:0] phys_addr,
  input logic [1:0]  seg_idx,
  input logic [3:0]  blk_sel
);
  logic [3:0] want_nib;
  always_comb begin
    case (cpu_addr[15:14])
      2'd0:    want_nib = pa_val[3:0];
      2'd1:    want_nib = pa_val[7:4];
      2'd2:    want_nib = pb_val[3:0];
      default: want_nib = pb_val[7:4];
    endcase
  end

  always_comb begin
    // R3
    row_bus_chk: assert (!row_phase || (ma[7:0] == phys_addr[7:0] && ma[8] == phys_addr[16]))
      else $error("row_bus_chk");
    // R4
    col_bus_chk: assert (row_phase || (ma[7:0] == phys_addr[15:8] && ma[8] == phys_addr[17]))
      else $error("col_bus_chk");
    // R1
    cpu_ofs_chk: assert (vid_own || (phys_addr[13:0] == cpu_addr[13:0] && phys_addr[17:14] == blk_sel))
      else $error("cpu_ofs_chk");
    // R6
    vid_seg_chk: assert (!vid_own || seg_idx == 2'd3)
      else $error("vid_seg_chk");
    // R7
    vid_addr_chk: assert (!vid_own || (phys_addr[13:0] == vid_addr && phys_addr[15:14] == ~vid_bank_n))
      else $error("vid_addr_chk");
    // R7
    vid_top_chk: assert (!(vid_own && pb_dir[7:6] == 2'b11) || phys_addr[17:16] == pb_val[7:6])
      else $error("vid_top_chk");
    // R2
    driven_map_chk: assert (!(!vid_own && pa_dir == 8'hFF && pb_dir == 8'hFF) || phys_addr[17:14] == want_nib)
      else $error("driven_map_chk");
    // R9
    boot_map_chk: assert (!(!vid_own && pa_dir == 8'h00 && pb_dir == 8'h00 && boot_hold)
                          || phys_addr[17:14] == (4'hC | {2'b00, cpu_addr[15:14]}))
      else $error("boot_map_chk");
  end
endmodule

bind dram_segmux dram_segmux_chk u_chk (
  .cpu_addr(cpu_addr), .vid_own(vid_own), .vid_addr(vid_addr),
  .vid_bank_n(vid_bank_n), .pa_val(pa_val), .pa_dir(pa_dir),
  .pb_val(pb_val), .pb_dir(pb_dir), .boot_hold(boot_hold),
  .row_phase(row_phase), .ma(ma), .phys_addr(phys_addr),
  .seg_idx(seg_idx), .blk_sel(blk_sel)
);

// File: tb/sim_dram_segmux.sv
module sim_dram_segmux;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [15:0] cpu;
    logic [7:0]  pa;
    logic [7:0]  pb;
    logic        vid;
    logic [13:0] va;
    logic [1:0]  vbn;
    logic [17:0] phys;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{16'h1234, 8'h5A, 8'h00, 1'b0, 14'h0000, 2'b00, 18'h29234},
    '{16'h4321, 8'h5A, 8'h00, 1'b0, 14'h0000, 2'b00, 18'h14321},
    '{16'h8FFF, 8'h00, 8'h73, 1'b0, 14'h0000, 2'b00, 18'h0CFFF},
    '{16'hFFFF, 8'h00, 8'h73, 1'b0, 14'h0000, 2'b00, 18'h1FFFF},
    '{16'hC000, 8'h00, 8'hF0, 1'b0, 14'h0000, 2'b00, 18'h3C000},
    '{16'h0000, 8'h00, 8'h00, 1'b0, 14'h0000, 2'b00, 18'h00000},
    '{16'h0000, 8'h5A, 8'h90, 1'b1, 14'h2ABC, 2'b10, 18'h26ABC},
    '{16'h0000, 8'h00, 8'h40, 1'b1, 14'h3FFF, 2'b00, 18'h1FFFF},
    '{16'h1234, 8'h00, 8'hC5, 1'b1, 14'h0000, 2'b11, 18'h30000},
    '{16'h7FFF, 8'hE0, 8'h00, 1'b0, 14'h0000, 2'b00, 18'h3BFFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        vid_own = 1'b0;
  logic [13:0] vid_addr = '0;
  logic [1:0]  vid_bank_n = '0;
  logic [7:0]  pa_val = '0, pa_dir = '0, pb_val = '0, pb_dir = '0;
  logic        row_phase = 1'b1;
  logic [8:0]  ma;
  logic [17:0] phys_addr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dram_segmux u0 (
    .cpu_addr(cpu_addr), .vid_own(vid_own), .vid_addr(vid_addr),
    .vid_bank_n(vid_bank_n), .pa_val(pa_val), .pa_dir(pa_dir),
    .pb_val(pb_val), .pb_dir(pb_dir), .boot_hold(rst),
    .row_phase(row_phase), .ma(ma), .phys_addr(phys_addr)
  );

  function automatic logic [8:0] exp_row(input logic [17:0] p);
    return 9'(((p >> 16) & 18'h1) << 8) | 9'(p & 18'hFF);
  endfunction
  function automatic logic [8:0] exp_col(input logic [17:0] p);
    return 9'(((p >> 17) & 18'h1) << 8) | 9'((p >> 8) & 18'hFF);
  endfunction

  task automatic settle();
    @(negedge clk);
    #(PERIOD/4);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // both bus phases of one physical address, R3 R4 R5
  task automatic chk_bus(input logic [17:0] p);
    row_phase = 1'b1; #1;
    chk("R3 row", 32'(ma), 32'(exp_row(p)));
    row_phase = 1'b0; #1;
    chk("R4 R5 col", 32'(ma), 32'(exp_col(p)));
    row_phase = 1'b1; #1;
  endtask

  function automatic string finish_line();
    return "";
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    // reset state: all lines floating, hold active -> C,D,E,F (R9, R8)
    settle();
    for (int s = 0; s < 4; s++) begin
      cpu_addr = 16'(s << 14) | 16'h0155;
      settle();
      chk("R9 boot map", 32'(phys_addr), 32'(((18'hC + 18'(s)) << 14) | 18'h0155));
    end
    chk_bus(phys_addr);
    rst = 1'b0;

    // floating lines without hold read high -> block F everywhere (R8)
    cpu_addr = 16'h0010;
    settle();
    chk("R8 float high", 32'(phys_addr), 32'h3C010);

    // table walk, all lines driven (R1 R2 R6 R7)
    pa_dir = 8'hFF; pb_dir = 8'hFF;
    for (int i = 0; i < NV; i++) begin
      cpu_addr = TBL[i].cpu; pa_val = TBL[i].pa; pb_val = TBL[i].pb;
      vid_own = TBL[i].vid; vid_addr = TBL[i].va; vid_bank_n = TBL[i].vbn;
      settle();
      chk(TBL[i].vid ? "R7 video phys" : "R1 R2 cpu phys", 32'(phys_addr), 32'(TBL[i].phys));
      chk_bus(TBL[i].phys);
    end

    // R6: processor address ignored during video fetch
    vid_own = 1'b1; pb_val = 8'h90; vid_addr = 14'h0123; vid_bank_n = 2'b01;
    cpu_addr = 16'h0000; settle();
    chk("R6 cpu ignored a", 32'(phys_addr), 32'h28123);
    cpu_addr = 16'h8ABC; settle();
    chk("R6 cpu ignored b", 32'(phys_addr), 32'h28123);

    // overlap: selector rewrite during video fetch (R7)
    pb_val = 8'hC0; settle();
    chk("R7 top follows pb", 32'(phys_addr), 32'h38123);
    chk_bus(18'h38123);
    vid_own = 1'b0;

    // R10: hold has no effect on driven lines
    pa_val = 8'h12; pb_val = 8'h34; rst = 1'b1;
    cpu_addr = 16'h0000; settle();
    chk("R10 hold on driven s0", 32'(phys_addr), 32'h08000);
    cpu_addr = 16'hC000; settle();
    chk("R10 hold on driven s3", 32'(phys_addr), 32'h0C000);

    // R8: half-driven port A with hold: low nibble driven 0, high reads 1101
    pa_dir = 8'h0F; pa_val = 8'h00;
    cpu_addr = 16'h0000; settle();
    chk("R8 mixed s0", 32'(phys_addr), 32'h00000);
    cpu_addr = 16'h4000; settle();
    chk("R8 mixed s1", 32'(phys_addr), 32'h34000);
    rst = 1'b0; settle();
    chk("R8 mixed released", 32'(phys_addr), 32'h3C000);

    report();
  end
endmodule